// File: doc/BRIEF.md
# Program Status Byte with Banked Working Registers

This block holds the flag byte of a small 8-bit microcontroller core together with the working register file. The flag byte can be written from a byte-wide bus or updated flag by flag from the ALU. An enable for each ALU flag says which of carry, auxiliary carry and overflow the ALU is updating in the current cycle.

Two bits of the flag byte choose one of four working register banks. A 3-bit register index from the instruction is combined with those two bits to form a 5-bit address into a 32-byte storage that holds all four banks. The parity bit is not written by software. On every clock it is reloaded from the accumulator input, so that the accumulator and the parity bit together always hold an even number of ones.

Top module: `bank_psw_core`

## Requirements
- R1: While `rst_n` is low, the status byte and all 32 register bytes are zero, which selects bank 0.
- R2: A bus write (`bus_we`=1) with no ALU enables loads bits 7..1 of `bus_wdata` into the status byte at the clock edge. Bit 7 is carry, bit 6 is auxiliary carry, bit 5 is a general flag, bits 4:3 are the bank select, bit 2 is overflow and bit 1 is a user flag.
- R3: A bus write has no effect on bit 0 (parity), whatever value `bus_wdata[0]` carries.
- R4: After every clock edge, `bus_rdata[0]` equals the XOR of the `acc` value sampled at that edge.
- R5: `alu_en[2]`, `alu_en[1]` and `alu_en[0]` load `alu_flags[2]` into carry (bit 7), `alu_flags[1]` into auxiliary carry (bit 6) and `alu_flags[0]` into overflow (bit 2). When neither a bus write nor an enable touches a flag, that flag keeps its value.
- R6: When a bus write and an ALU enable fall in the same cycle, each enabled flag takes its ALU value and every other writable bit takes its bus value.
- R7: `rf_addr` equals {bank select bits 4:3, `rf_idx`}. Bank 00, 01, 10 and 11 cover addresses 00h-07h, 08h-0Fh, 10h-17h and 18h-1Fh.
- R8: With `rf_we`=1, `rf_wdata` is stored at `rf_addr` on the clock edge. `rf_rdata` always shows the byte stored at the current `rf_addr`.
- R9: A register access in the same cycle as a bus write that changes the bank select uses the old bank. The new bank applies from the following cycle.
- R10: The same index in different banks refers to separate bytes. A write in one bank leaves the other three banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Bus write strobe for the status byte |
| bus_wdata | input | 8 | Bus write data |
| bus_rdata | output | 8 | Current status byte |
| alu_en | input | 3 | Per-flag update enables {carry, aux carry, overflow} |
| alu_flags | input | 3 | ALU flag values {carry, aux carry, overflow} |
| acc | input | 8 | Accumulator value used for parity |
| rf_idx | input | 3 | Working register index |
| rf_we | input | 1 | Register write strobe |
| rf_wdata | input | 8 | Register write data |
| rf_rdata | output | 8 | Register read data |
| rf_addr | output | 5 | Resolved register file address |

## Verification
The hardest case to reach is a bus write that changes the bank select in the same cycle as a register write. That one cycle is the only place where the old and new bank can be told apart. The stimulus aims at it directly: it writes a register during the bank switch and then reads the same index in both banks. It also drives bus writes and ALU enables together, and puts odd parity on `bus_wdata[0]` against an even accumulator. A long stretch of mixed random traffic is then compared on every cycle with a behavioural model.

// File: rtl/psw_bank_pkg.sv
package psw_bank_pkg;
  localparam int BYTE_W  = 8;
  localparam int IDX_W   = 3;
  localparam int BANK_W  = 2;
  localparam int RADDR_W = IDX_W + BANK_W;
  localparam int NFLAG   = 3;

  localparam int CY_BIT  = 7;
  localparam int AC_BIT  = 6;
  localparam int BS_HI   = 4;
  localparam int BS_LO   = 3;
  localparam int OV_BIT  = 2;
  localparam int PAR_BIT = 0;

  // ALU enable/flag vector slots
  localparam int ALU_OV = 0;
  localparam int ALU_AC = 1;
  localparam int ALU_CY = 2;

  function automatic logic even_fill(input logic [BYTE_W-1:0] a);
    return ^a;
  endfunction

  function automatic logic [RADDR_W-1:0] bank_addr(input logic [BANK_W-1:0] bank,
                                                   input logic [IDX_W-1:0] idx);
    return {bank, idx};
  endfunction
endpackage

// File: rtl/psw_status_reg.sv
module psw_status_reg
  import psw_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic [NFLAG-1:0]  alu_en,
  input  logic [NFLAG-1:0]  alu_flags,
  input  logic [BYTE_W-1:0] acc,
  output logic [BYTE_W-1:0] status,
  output logic [BANK_W-1:0] bank_sel
);
  localparam int FLAG_POS [NFLAG] = '{OV_BIT, AC_BIT, CY_BIT};

  logic [BYTE_W-1:0] bus_stage;
  logic [BYTE_W-1:0] status_d;

  always_comb begin
    bus_stage = status;
    if (bus_we) bus_stage[BYTE_W-1:1] = bus_wdata[BYTE_W-1:1];
  end

  always_comb begin
    status_d = bus_stage;
    for (int f = 0; f < NFLAG; f++)
      if (alu_en[f]) status_d[FLAG_POS[f]] = alu_flags[f];
    status_d[PAR_BIT] = even_fill(acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= status_d;
  end

  assign bank_sel = status[BS_HI:BS_LO];
endmodule

// File: rtl/psw_reg_bank.sv
module psw_reg_bank #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (we) begin
      mem[addr] <= wdata;
    end
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/bank_psw_core.sv
module bank_psw_core
  import psw_bank_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [BYTE_W-1:0]  bus_wdata,
  output logic [BYTE_W-1:0]  bus_rdata,
  input  logic [NFLAG-1:0]   alu_en,
  input  logic [NFLAG-1:0]   alu_flags,
  input  logic [BYTE_W-1:0]  acc,
  input  logic [IDX_W-1:0]   rf_idx,
  input  logic               rf_we,
  input  logic [BYTE_W-1:0]  rf_wdata,
  output logic [BYTE_W-1:0]  rf_rdata,
  output logic [RADDR_W-1:0] rf_addr
);
  logic [BANK_W-1:0] bank_sel;

  psw_status_reg u_status (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .alu_en(alu_en), .alu_flags(alu_flags), .acc(acc),
    .status(bus_rdata), .bank_sel(bank_sel)
  );

  assign rf_addr = bank_addr(bank_sel, rf_idx);

  psw_reg_bank #(.ADDR_W(RADDR_W), .DATA_W(BYTE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(rf_addr), .we(rf_we),
    .wdata(rf_wdata), .rdata(rf_rdata)
  );
endmodule

// File: rtl/psw_bank_chk.sv
module psw_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_we,
  input logic [7:0] bus_wdata,
  input logic [7:0] bus_rdata,
  input logic [2:0] alu_en,
  input logic [2:0] alu_flags,
  input logic [7:0] acc,
  input logic [2:0] rf_idx,
  input logic       rf_we,
  input logic [7:0] rf_wdata,
  input logic [7:0] rf_rdata,
  input logic [4:0] rf_addr,
  input logic [1:0] bank_sel
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) !rst_n |=> bus_rdata == 8'h00);

  // R2
  bus_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && alu_en == 3'b000) |=> bus_rdata[7:1] == $past(bus_wdata[7:1]));

  // R4
  parity_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> bus_rdata[0] == ^$past(acc));

  // R5
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && !alu_en[2]) |=> bus_rdata[7] == $past(bus_rdata[7]));

  // R6
  alu_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && alu_en[2]) |=> (bus_rdata[7] == $past(alu_flags[2]) &&
                               bus_rdata[5] == $past(bus_wdata[5])));

  // R7
  addr_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_addr == {bus_rdata[4:3], rf_idx});

  // R8
  reg_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> (rf_addr != $past(rf_addr) || rf_rdata == $past(rf_wdata)));

  // R9
  bank_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> bank_sel == $past(bus_wdata[4:3]));
endmodule

bind bank_psw_core psw_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .alu_en(alu_en), .alu_flags(alu_flags), .acc(acc),
  .rf_idx(rf_idx), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
  .rf_addr(rf_addr), .bank_sel(bank_sel)
);

// File: tb/tb_bank_psw_core.sv
`timescale 1ns/1ps
module tb_bank_psw_core;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       bus_we = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [2:0] alu_en = 0;
  logic [2:0] alu_flags = 0;
  logic [7:0] acc = 0;
  logic [2:0] rf_idx = 0;
  logic       rf_we = 0;
  logic [7:0] rf_wdata = 0;
  logic [7:0] rf_rdata;
  logic [4:0] rf_addr;

  int n_run = 0;
  int n_fail = 0;

  // reference state
  int m_psw = 0;
  int m_mem [32];

  always #4 clk = ~clk;

  bank_psw_core dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .alu_en(alu_en), .alu_flags(alu_flags), .acc(acc),
    .rf_idx(rf_idx), .rf_we(rf_we), .rf_wdata(rf_wdata), .rf_rdata(rf_rdata),
    .rf_addr(rf_addr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int par_of(input int v);
    int c = 0;
    for (int b = 0; b < 8; b++) c += (v >> b) & 1;
    return c % 2;
  endfunction

  task automatic compare(input string stag, input string rtag);
    int a = ((m_psw >> 3) & 3) * 8 + int'(rf_idx);
    check(int'(bus_rdata[7:1]) == (m_psw >> 1), stag, bus_rdata[7:1], m_psw >> 1);
    check(bus_rdata[0] == m_psw[0], "R4 parity", bus_rdata[0], m_psw & 1);
    check(int'(rf_addr) == a, "R7 rf_addr", rf_addr, a);
    check(int'(rf_rdata) == m_mem[a], rtag, rf_rdata, m_mem[a]);
  endtask

  task automatic step(input bit bwe, input logic [7:0] bwd, input logic [2:0] aen,
                      input logic [2:0] afl, input logic [7:0] a, input logic [2:0] idx,
                      input bit we, input logic [7:0] wd, input string stag, input string rtag);
    int addr;
    bus_we = bwe; bus_wdata = bwd; alu_en = aen; alu_flags = afl; acc = a;
    rf_idx = idx; rf_we = we; rf_wdata = wd;
    #1;
    compare(stag, rtag);
    @(posedge clk);
    addr = ((m_psw >> 3) & 3) * 8 + int'(idx);
    if (we) m_mem[addr] = int'(wd);
    if (bwe) m_psw = (int'(bwd) & 8'hFE) | (m_psw & 1);
    if (aen[2]) m_psw = (m_psw & 8'h7F) | (int'(afl[2]) << 7);
    if (aen[1]) m_psw = (m_psw & 8'hBF) | (int'(afl[1]) << 6);
    if (aen[0]) m_psw = (m_psw & 8'hFB) | (int'(afl[0]) << 2);
    m_psw = (m_psw & 8'hFE) | par_of(int'(a));
    @(negedge clk);
  endtask

  task automatic idle(input logic [2:0] idx, input string rtag);
    step(0, 8'h00, 3'b000, 3'b000, acc, idx, 0, 8'h00, "R5 hold", rtag);
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    // R1: status reads zero during reset
    check(bus_rdata == 8'h00, "R1 reset status", bus_rdata, 0);
    check(rf_rdata == 8'h00, "R1 reset reg", rf_rdata, 0);
    rst_n = 1;
    @(negedge clk);
    // R1: every bank/index zero after reset
    for (int b = 0; b < 4; b++) begin
      step(1, 8'(b << 3), 3'b000, 3'b000, 8'h00, 3'd0, 0, 8'h00, "R2 bank write", "R1 reg zero");
      for (int i = 0; i < 8; i++) idle(3'(i), "R1 reg zero");
    end
    // R2: full bus load
    step(1, 8'hE6, 3'b000, 3'b000, 8'h01, 3'd0, 0, 8'h00, "R2 bus load", "R8 read");
    idle(3'd0, "R8 read");
    // R3: bit0 of bus data ignored; acc even -> parity 0
    step(1, 8'h01, 3'b000, 3'b000, 8'h03, 3'd0, 0, 8'h00, "R2 bus load", "R8 read");
    check(bus_rdata[0] == 1'b0, "R3 parity not bus-written", bus_rdata[0], 0);
    step(1, 8'h00, 3'b000, 3'b000, 8'h07, 3'd0, 0, 8'h00, "R2 bus load", "R8 read");
    check(bus_rdata[0] == 1'b1, "R3 parity from acc", bus_rdata[0], 1);
    // R5: individual ALU enables
    step(0, 8'h00, 3'b100, 3'b111, 8'h00, 3'd0, 0, 8'h00, "R5 alu", "R8 read");
    step(0, 8'h00, 3'b010, 3'b111, 8'h00, 3'd0, 0, 8'h00, "R5 alu", "R8 read");
    step(0, 8'h00, 3'b001, 3'b111, 8'h00, 3'd0, 0, 8'h00, "R5 alu", "R8 read");
    step(0, 8'h00, 3'b101, 3'b000, 8'h00, 3'd0, 0, 8'h00, "R5 alu", "R8 read");
    idle(3'd0, "R8 read");
    check(bus_rdata == 8'h40, "R5 flags after enables", bus_rdata, 8'h40);
    // R6: bus and ALU together
    step(1, 8'hFE, 3'b101, 3'b000, 8'h00, 3'd0, 0, 8'h00, "R6 priority", "R8 read");
    idle(3'd0, "R8 read");
    check(bus_rdata == 8'h7A, "R6 priority result", bus_rdata, 8'h7A);
    step(1, 8'h00, 3'b010, 3'b010, 8'h00, 3'd0, 0, 8'h00, "R6 priority", "R8 read");
    idle(3'd0, "R8 read");
    check(bus_rdata == 8'h40, "R6 priority result", bus_rdata, 8'h40);
    // R10: same index, distinct value per bank
    for (int b = 0; b < 4; b++) begin
      step(1, 8'(b << 3), 3'b000, 3'b000, 8'h00, 3'd5, 0, 8'h00, "R2 bank write", "R8 read");
      step(0, 8'h00, 3'b000, 3'b000, 8'h00, 3'd5, 1, 8'(8'hA0 + b), "R5 hold", "R10 bank");
    end
    for (int b = 0; b < 4; b++) begin
      step(1, 8'(b << 3), 3'b000, 3'b000, 8'h00, 3'd5, 0, 8'h00, "R2 bank write", "R10 bank");
      idle(3'd5, "R10 bank");
      check(rf_rdata == 8'(8'hA0 + b), "R10 bank value", rf_rdata, 8'hA0 + b);
    end
    // R9: bank switch 3 -> 1 with a simultaneous register write goes to bank 3
    step(1, 8'h08, 3'b000, 3'b000, 8'h00, 3'd2, 1, 8'h5C, "R9 switch", "R9 old bank");
    idle(3'd2, "R9 new bank");
    check(rf_addr == 5'h0A && rf_rdata == 8'h00, "R9 new bank untouched", rf_rdata, 0);
    step(1, 8'h18, 3'b000, 3'b000, 8'h00, 3'd2, 0, 8'h00, "R9 switch", "R9 new bank");
    idle(3'd2, "R9 old bank");
    check(rf_addr == 5'h1A && rf_rdata == 8'h5C, "R9 write landed in old bank", rf_rdata, 8'h5C);
    // mixed random traffic
    for (int k = 0; k < 400; k++) begin
      step(1'($urandom_range(0, 3) == 0), 8'($urandom), 3'($urandom), 3'($urandom),
           8'($urandom), 3'($urandom), 1'($urandom), 8'($urandom), "R6 mixed", "R8 mixed");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule